// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a two-wire serial target that gives a host controller access to a bank of byte-wide configuration registers. A faster system clock oversamples the serial clock and data lines. Each line passes through a synchronizer and a glitch filter. Start and stop conditions are found from data edges that occur while the filtered clock is high. The block acknowledges by pulling the data line low through an open-drain enable. It shifts read data out the same way.

The command byte sent after the device address selects one of two access modes. In indexed mode one register is reached at a 7-bit offset. In sequential (block) mode the transfer always begins at register 0 and walks upward. A block write carries a byte count ahead of its data. A block read returns a byte count ahead of its data. The bank holds three kinds of byte: writable configuration bytes with fixed reset values, read-only status bytes taken from an input port, and two constant identification bytes. The writable bytes are presented on a flat output bus for the surrounding logic.

Top module: `smb_ctl_target`

## Requirements
- R1: The block acknowledges only the 7-bit device address 69h (address byte D2h for a write, D3h for a read). Any other address is not acknowledged, and the block ignores the rest of that transfer.
- R2: A command byte with bit 7 = 1 selects indexed access at the offset held in bits 6:0. A following data byte is written to that offset.
- R3: A command byte with bit 7 = 0 selects sequential access starting at offset 0. Successive data bytes go to offsets 0, 1, 2 and so on.
- R4: In a sequential write, the first byte after the command is a byte count. It is acknowledged and is not stored in any register. Every later byte is acknowledged and written in turn.
- R5: A sequential read, after a repeated start with the read bit, first returns the byte-count register (offset 15). It then returns offsets 0, 1, 2 and so on, for as long as the host acknowledges.
- R6: An indexed read (command write, repeated start, read) returns the register at the selected offset.
- R7: After reset the writable bytes hold: offset 0 = EFh, 1 = C0h, 2 = FFh, 3 = F0h, 15 = 16h, 16 = 40h, 17..21 = 00h.
- R8: Offsets 4..10 read back the status input, with offset 4+k taken from bits 8k+7:8k. Offset 11 reads 81h, offset 12 reads A0h, and offsets 13..14 read 00h. Writes to offsets 4..14 are acknowledged and discarded.
- R9: Offsets 22 and above read 00h. Writes to them are acknowledged and discarded.
- R10: A stop after any complete byte ends the transfer. Bytes already completed stay written, and the data line is released.
- R11: The block changes its data-line drive only while the filtered clock is low, and releases the line after any start condition.
- R12: `cfg_o` presents writable byte i at bits 8i+7:8i. Bytes that are not writable read as 0 on this bus. The bus changes only while the filtered clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain) |
| hw_status_i | input | RO_COUNT*8 | Read-only status bytes for offsets 4..10 |
| cfg_o | output | REG_COUNT*8 | Writable configuration bytes, byte i at bits 8i+7:8i |

## Verification
Directed transfers cover each access form:
- indexed write and read
- sequential write with a declared count
- sequential read that checks the count byte first
- a foreign address
- writes to status, constant and out-of-range offsets
- a sequential write cut short by a stop

These transfers separate the two command modes. They also show that the count byte is never stored, and that discarded writes leave both the bus and the read-back untouched. A seeded random mix of indexed reads and writes to offsets 0..31 then compares every read against a register model kept in the bench. This shows that write decoding and read multiplexing agree across every class of offset, including after the byte-count register itself has been rewritten.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

   typedef enum logic [2:0] {
      LNK_IDLE,
      LNK_RX,
      LNK_RACK,
      LNK_TX,
      LNK_TACK
   } lnk_state_e;

   typedef enum logic [1:0] {
      RX_ADDR,
      RX_CMD,
      RX_COUNT,
      RX_DATA
   } rx_kind_e;

   // Power-up value of a writable configuration byte.
   function automatic logic [7:0] reset_value(input int idx);
      case (idx)
         0:       return 8'hEF;
         1:       return 8'hC0;
         2:       return 8'hFF;
         3:       return 8'hF0;
         15:      return 8'h16;
         16:      return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [1:0] sync_q;
   logic       upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], pin_i};
   end

   generate
      if (FILT_LEN <= 1) begin : g_bypass
         assign upd = (sync_q[1] != level_o);
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN + 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 run_q <= '0;
            else if (sync_q[1] == level_o || upd) run_q <= '0;
            else                        run_q <= run_q + 1'b1;
         end
         assign upd = (sync_q[1] != level_o) && (int'(run_q) == FILT_LEN - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b1;
         rise_o  <= 1'b0;
         fall_o  <= 1'b0;
      end else begin
         rise_o <= upd &  sync_q[1];
         fall_o <= upd & ~sync_q[1];
         if (upd) level_o <= sync_q[1];
      end
   end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_tgt_pkg::*;
#(
   parameter int                   REG_COUNT = 22,
   parameter logic [REG_COUNT-1:0] WR_MASK   = 22'h3F800F,
   parameter int                   RO_BASE   = 4,
   parameter int                   RO_COUNT  = 7,
   parameter int                   ID0_OFF   = 11,
   parameter int                   ID1_OFF   = 12,
   parameter logic [7:0]           ID0_VAL   = 8'h81,
   parameter logic [7:0]           ID1_VAL   = 8'hA0,
   parameter int                   CNT_OFF   = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [6:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic [6:0]             rd_addr,
   output logic [7:0]             rd_data,
   output logic [7:0]             cnt_o,
   input  logic [RO_COUNT*8-1:0]  hw_status_i,
   output logic [REG_COUNT*8-1:0] cfg_o
);
   localparam int IDX_W  = $clog2(REG_COUNT);
   localparam int VIEW_N = 2 ** IDX_W;

   logic [7:0] view [VIEW_N];

   for (genvar i = 0; i < VIEW_N; i++) begin : g_slot
      if (i >= REG_COUNT) begin : g_none
         assign view[i] = 8'h00;
      end else if (WR_MASK[i]) begin : g_wr
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= reset_value(i);
            else if (wr_en && int'(wr_addr) == i) q <= wr_data;
         end
         assign view[i]           = q;
         assign cfg_o[i*8 +: 8]   = q;
      end else begin : g_fixed
         if (i >= RO_BASE && i < RO_BASE + RO_COUNT) begin : g_ro
            assign view[i] = hw_status_i[(i-RO_BASE)*8 +: 8];
         end else if (i == ID0_OFF) begin : g_id0
            assign view[i] = ID0_VAL;
         end else if (i == ID1_OFF) begin : g_id1
            assign view[i] = ID1_VAL;
         end else begin : g_rsv
            assign view[i] = 8'h00;
         end
         assign cfg_o[i*8 +: 8] = 8'h00;
      end
   end

   assign rd_data = (int'(rd_addr) < REG_COUNT) ? view[rd_addr[IDX_W-1:0]] : 8'h00;
   assign cnt_o   = view[CNT_OFF];
endmodule

// File: rtl/smb_link.sv
module smb_link
   import smb_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_lvl,
   input  logic       start_p,
   input  logic       stop_p,
   output logic       sda_oe_o,
   output logic       wr_en_o,
   output logic [6:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic [6:0] rd_addr_o,
   input  logic [7:0] rd_data_i,
   input  logic [7:0] cnt_i
);
   lnk_state_e st_q;
   rx_kind_e   kind_q;
   logic [7:0] sh_q;
   logic [3:0] bit_q;
   logic [6:0] ptr_q;
   logic       cnt_first_q, go_tx_q, acked_q;
   logic [7:0] tx_next;

   assign rd_addr_o = ptr_q;
   assign tx_next   = cnt_first_q ? cnt_i : rd_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LNK_IDLE;  kind_q <= RX_ADDR;  sh_q <= '0;  bit_q <= '0;
         ptr_q <= '0;  cnt_first_q <= 1'b0;  go_tx_q <= 1'b0;  acked_q <= 1'b0;
         sda_oe_o <= 1'b0;  wr_en_o <= 1'b0;  wr_addr_o <= '0;  wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_p) begin
            st_q <= LNK_RX;  kind_q <= RX_ADDR;  bit_q <= '0;  sda_oe_o <= 1'b0;
         end else if (stop_p) begin
            st_q <= LNK_IDLE;  sda_oe_o <= 1'b0;
         end else begin
            case (st_q)
               LNK_RX: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[6:0], sda_lvl};
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall && bit_q == 4'd8) begin
                     bit_q    <= '0;
                     st_q     <= LNK_RACK;
                     sda_oe_o <= 1'b1;
                     go_tx_q  <= 1'b0;
                     case (kind_q)
                        RX_ADDR: begin
                           if (sh_q[7:1] == DEV_ADDR) begin
                              go_tx_q <= sh_q[0];
                              kind_q  <= RX_CMD;
                           end else begin
                              st_q     <= LNK_IDLE;
                              sda_oe_o <= 1'b0;
                           end
                        end
                        RX_CMD: begin
                           cnt_first_q <= ~sh_q[7];
                           ptr_q       <= sh_q[7] ? sh_q[6:0] : 7'd0;
                           kind_q      <= sh_q[7] ? RX_DATA : RX_COUNT;
                        end
                        RX_COUNT: kind_q <= RX_DATA;
                        default: begin
                           wr_en_o   <= 1'b1;
                           wr_addr_o <= ptr_q;
                           wr_data_o <= sh_q;
                           ptr_q     <= ptr_q + 1'b1;
                        end
                     endcase
                  end
               end
               LNK_RACK, LNK_TACK: begin
                  if (scl_rise) acked_q <= ~sda_lvl;
                  if (scl_fall) begin
                     if ((st_q == LNK_RACK && go_tx_q) || (st_q == LNK_TACK && acked_q)) begin
                        sh_q     <= tx_next;
                        sda_oe_o <= ~tx_next[7];
                        bit_q    <= '0;
                        st_q     <= LNK_TX;
                        if (cnt_first_q) cnt_first_q <= 1'b0;
                        else             ptr_q       <= ptr_q + 1'b1;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st_q     <= (st_q == LNK_RACK) ? LNK_RX : LNK_IDLE;
                     end
                  end
               end
               LNK_TX: begin
                  if (scl_fall) begin
                     if (bit_q == 4'd7) begin
                        sda_oe_o <= 1'b0;
                        st_q     <= LNK_TACK;
                     end else begin
                        sh_q     <= {sh_q[6:0], 1'b0};
                        sda_oe_o <= ~sh_q[6];
                        bit_q    <= bit_q + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smb_ctl_target.sv
module smb_ctl_target
   import smb_tgt_pkg::*;
#(
   parameter int                   REG_COUNT = 22,
   parameter logic [REG_COUNT-1:0] WR_MASK   = 22'h3F800F,
   parameter int                   RO_BASE   = 4,
   parameter int                   RO_COUNT  = 7,
   parameter int                   CNT_OFF   = 15,
   parameter int                   FILT_LEN  = 3,
   parameter logic [6:0]           DEV_ADDR  = 7'h69
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe_o,
   input  logic [RO_COUNT*8-1:0]  hw_status_i,
   output logic [REG_COUNT*8-1:0] cfg_o
);
   if (REG_COUNT < 2 || REG_COUNT > 128) begin : g_bad_count
      $error("REG_COUNT must lie in 2..128");
   end
   if (CNT_OFF >= REG_COUNT || RO_BASE + RO_COUNT > REG_COUNT) begin : g_bad_map
      $error("register map exceeds REG_COUNT");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
   logic start_p, stop_p;
   logic       wr_en;
   logic [6:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data, cnt_val;

   smb_pin_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   smb_pin_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   assign start_p = sda_fall & scl_lvl;
   assign stop_p  = sda_rise & scl_lvl;

   smb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .start_p(start_p), .stop_p(stop_p), .sda_oe_o(sda_oe_o),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data), .cnt_i(cnt_val));

   smb_reg_bank #(
      .REG_COUNT(REG_COUNT), .WR_MASK(WR_MASK), .RO_BASE(RO_BASE),
      .RO_COUNT(RO_COUNT), .CNT_OFF(CNT_OFF)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_o(cnt_val),
      .hw_status_i(hw_status_i), .cfg_o(cfg_o));
endmodule

// File: rtl/smb_ctl_target_chk.sv
module smb_ctl_target_chk
   import smb_tgt_pkg::*;
#(
   parameter int                   REG_COUNT = 22,
   parameter logic [REG_COUNT-1:0] WR_MASK   = 22'h3F800F
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_lvl,
   input logic                   start_p,
   input logic                   stop_p,
   input logic                   sda_oe,
   input logic [REG_COUNT*8-1:0] cfg
);
   function automatic logic [REG_COUNT*8-1:0] def_flat();
      logic [REG_COUNT*8-1:0] v = '0;
      for (int i = 0; i < REG_COUNT; i++)
         if (WR_MASK[i]) v[i*8 +: 8] = reset_value(i);
      return v;
   endfunction

   // R7
   reset_val_chk: assert property (@(posedge clk) $rose(rst_n) |-> cfg == def_flat());

   // R11
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe));

   // R11
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_oe);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe);

   // R12
   cfg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg) |-> !scl_lvl);
endmodule

bind smb_ctl_target smb_ctl_target_chk #(.REG_COUNT(REG_COUNT), .WR_MASK(WR_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_p(start_p),
   .stop_p(stop_p), .sda_oe(sda_oe_o), .cfg(cfg_o));

// File: tb/smb_ctl_target_tb.sv
module smb_ctl_target_tb;
   localparam int NREG = 22;
   localparam int NRO  = 7;
   localparam int HP   = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe, sda_line;
   logic [NRO*8-1:0]  hw;
   logic [NREG*8-1:0] cfg;
   logic [7:0] mdl [NREG];
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   smb_ctl_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .hw_status_i(hw), .cfg_o(cfg));

   function automatic bit is_wr(int off);
      return (off >= 0 && off <= 3) || (off >= 15 && off < NREG);
   endfunction

   function automatic logic [7:0] def_of(int off);
      case (off)
         0: return 8'hEF;  1: return 8'hC0;  2: return 8'hFF;  3: return 8'hF0;
         15: return 8'h16; 16: return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(int off);
      if (off >= NREG)          return 8'h00;
      if (is_wr(off))           return mdl[off];
      if (off >= 4 && off <= 10) return hw[(off-4)*8 +: 8];
      if (off == 11)            return 8'h81;
      if (off == 12)            return 8'hA0;
      return 8'h00;
   endfunction

   function automatic logic [NREG*8-1:0] exp_cfg();
      logic [NREG*8-1:0] v = '0;
      for (int i = 0; i < NREG; i++) if (is_wr(i)) v[i*8 +: 8] = mdl[i];
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt();
      repeat (HP) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; m_scl = 1'b1; wt(); m_sda = 1'b0; wt(); m_scl = 1'b0;
   endtask

   task automatic m_rstart();
      wt(); m_sda = 1'b1; wt(); m_scl = 1'b1; wt(); m_sda = 1'b0; wt(); m_scl = 1'b0;
   endtask

   task automatic m_stop();
      wt(); m_sda = 1'b0; wt(); m_scl = 1'b1; wt(); m_sda = 1'b1; wt();
   endtask

   task automatic m_send(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         wt(); m_sda = b[i]; wt(); m_scl = 1'b1; wt(); m_scl = 1'b0;
      end
      wt(); m_sda = 1'b1; wt(); m_scl = 1'b1; wt(); ack = ~sda_line; m_scl = 1'b0;
   endtask

   task automatic m_recv(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(); wt(); m_scl = 1'b1; wt(); b[i] = sda_line; m_scl = 1'b0;
      end
      wt(); m_sda = ~give_ack; wt(); m_scl = 1'b1; wt(); m_scl = 1'b0;
      wt(); m_sda = 1'b1;
   endtask

   task automatic byte_wr(input int off, input logic [7:0] v, input string req);
      bit a0, a1, a2;
      m_start(); m_send(8'hD2, a0); m_send(8'h80 | 8'(off), a1); m_send(v, a2); m_stop();
      check(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
      if (is_wr(off)) mdl[off] = v;
   endtask

   task automatic byte_rd(input int off, input string req);
      bit a0, a1, a2;
      logic [7:0] v;
      m_start(); m_send(8'hD2, a0); m_send(8'h80 | 8'(off), a1);
      m_rstart(); m_send(8'hD3, a2); m_recv(1'b0, v); m_stop();
      check(a0 && a1 && a2 && v === exp_rd(off), req, v, exp_rd(off));
   endtask

   initial begin
      bit a0, a1, a2, ak;
      logic [7:0] v;
      void'($urandom(32'd1357));
      hw = {$urandom, $urandom};
      for (int i = 0; i < NREG; i++) mdl[i] = is_wr(i) ? def_of(i) : 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R7 R12: reset values on the configuration bus
      check(cfg === exp_cfg(), "R7 reset cfg", cfg, exp_cfg());
      check(sda_oe === 1'b0, "R11 idle release", sda_oe, 0);
      // R6 R7: indexed reads of defaults
      byte_rd(0, "R6 R7 read off0");
      byte_rd(2, "R6 R7 read off2");
      byte_rd(16, "R6 R7 read off16");
      // R2 R12: indexed write then bus and read-back
      byte_wr(1, 8'h5A, "R2 write off1");
      check(cfg === exp_cfg(), "R12 cfg after write", cfg, exp_cfg());
      byte_rd(1, "R2 R6 readback off1");
      // R8: status, constants, reserved; writes discarded
      byte_rd(5, "R8 status off5");
      byte_rd(10, "R8 status off10");
      byte_rd(11, "R8 id off11");
      byte_rd(12, "R8 id off12");
      byte_wr(6, 8'h33, "R8 write ro ack");
      byte_rd(6, "R8 ro unchanged");
      byte_wr(13, 8'h77, "R8 write rsv ack");
      byte_rd(13, "R8 rsv reads zero");
      check(cfg === exp_cfg(), "R8 cfg unchanged", cfg, exp_cfg());
      // R9: out of range offsets
      byte_wr(40, 8'h99, "R9 write high ack");
      byte_rd(40, "R9 read high zero");
      check(cfg === exp_cfg(), "R9 cfg unchanged", cfg, exp_cfg());
      // R1: foreign address is not acknowledged, transfer ignored
      m_start(); m_send(8'hD4, a0); m_send(8'h80, a1); m_send(8'h00, a2); m_stop();
      check(!a0, "R1 foreign address nak", a0, 0);
      check(cfg === exp_cfg(), "R1 foreign write ignored", cfg, exp_cfg());

      // R3 R4: block write of 6 bytes, count 6 not stored
      m_start(); m_send(8'hD2, a0); m_send(8'h00, a1); m_send(8'd6, a2);
      check(a0 && a1 && a2, "R4 count ack", {a0, a1, a2}, 3'b111);
      for (int i = 0; i < 6; i++) begin
         v = 8'(8'h21 + 8'(i * 16));
         m_send(v, ak);
         check(ak, "R4 data ack", ak, 1);
         if (is_wr(i)) mdl[i] = v;
      end
      m_stop();
      check(cfg === exp_cfg(), "R3 R4 block write cfg", cfg, exp_cfg());

      // R5: block read, count first then ascending offsets
      m_start(); m_send(8'hD2, a0); m_send(8'h00, a1); m_rstart(); m_send(8'hD3, a2);
      m_recv(1'b1, v);
      check(v === mdl[15], "R5 count byte", v, mdl[15]);
      for (int i = 0; i < 7; i++) begin
         m_recv(i != 6, v);
         check(v === exp_rd(i), "R5 block data", v, exp_rd(i));
      end
      m_stop();

      // R10: block write cut short after two data bytes
      m_start(); m_send(8'hD2, a0); m_send(8'h00, a1); m_send(8'd5, a2);
      m_send(8'hA1, ak); m_send(8'hB2, ak); m_stop();
      mdl[0] = 8'hA1; mdl[1] = 8'hB2;
      check(cfg === exp_cfg(), "R10 partial block", cfg, exp_cfg());
      check(sda_oe === 1'b0, "R10 released after stop", sda_oe, 0);

      // R2 R6 R8 R9: seeded random indexed traffic
      for (int k = 0; k < 40; k++) begin
         int off = int'($urandom % 32);
         if ($urandom % 2) byte_wr(off, 8'($urandom), "R2 random write");
         else              byte_rd(off, "R6 random read");
      end
      check(cfg === exp_cfg(), "R12 final cfg", cfg, exp_cfg());
      // R5: block read count after random traffic
      m_start(); m_send(8'hD2, a0); m_send(8'h00, a1); m_rstart(); m_send(8'hD3, a2);
      m_recv(1'b0, v); m_stop();
      check(v === mdl[15], "R5 count after traffic", v, mdl[15]);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule